// File: doc/BRIEF.md
# Sampling Phase Window Selector

This block chooses a receive sampling phase for a high-speed card interface. After a start command it walks through all sixteen sampling phases in ascending order. For each phase it asks an external test engine to run a trial transfer, and it records whether that trial passed. From the resulting 16-bit pass mask it finds the longest circular run of passing phases and reports the phase three quarters of the way into that run. A sweep with no passing phase is repeated. After three empty sweeps the block gives up with an I/O error.

The sixteen phases form a circle. A run that touches phase 15 and a separate run that starts at phase 0 are therefore one window. That window starts at the phase-15 side and continues through phase 0. At low clock rates, and in bus modes that need no tuning, the block skips the sweep and reports completion at once.

The controller has five states. IDLE waits for start. PROBE holds a request for the current phase until the result arrives. GAP drops the request for one cycle and then takes one of four paths: next phase, retry, give up or scan. SCAN waits for the window scanner. DONE pulses completion. The transitions are:
- IDLE→DONE on a bypassed start.
- IDLE→PROBE on a tuned start.
- PROBE→GAP on a result.
- GAP→PROBE to advance the phase or to retry an empty sweep.
- GAP→SCAN when the sweep holds a pass.
- GAP→DONE on the third empty sweep.
- SCAN→DONE when the scan finishes.
- DONE→IDLE.

Top module: `phase_window_tuner`

## Requirements
- R1: After reset, `busy`, `done`, `probe_req`, `err_nopass` and `err_select` are 0 and `sel_phase` is 0.
- R2: A tuned start requests phases 0,1,…,15 in order, one request each. `probe_req` stays high with a stable `probe_phase` until `probe_valid`, then drops for at least one cycle.
- R3: A start is bypassed when `freq_mhz` ≤ 100 or when `bus_mode` is neither 3 nor 4 (the two fastest single-data-rate modes). A bypassed start makes no request and gives `done` on the next cycle with both error flags 0 and `sel_phase` 0.
- R4: The chosen window is the longest run of consecutive passing phases on the circle. When phases 0 and 15 both pass and the mask is not all ones, the run ending at 15 and the run starting at 0 form one window that begins on the phase-15 side. With all sixteen passing, the window starts at 0 with length 16.
- R5: When windows tie in length, the one whose start phase is lowest wins. A wrapped window counts as starting at its phase-15-side start.
- R6: With window length L and start S, the offset is k = floor(3L/4), reduced by one when nonzero, and `sel_phase` = (S + k) mod 16.
- R7: A sweep with no passing phase is repeated from phase 0, up to three sweeps in total. If the third sweep is also empty, `done` comes with `err_nopass` = 1 and `sel_phase` = 0 after 48 requests. Otherwise the first non-empty sweep decides the result.
- R8: `done` is a single-cycle pulse. The results stay unchanged until the next accepted start. A start while `busy` is ignored.
- R9: `done` is asserted no more than 32 cycles after the last phase result of the deciding sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| start | input | 1 | Begin a tuning run (single-cycle pulse) |
| freq_mhz | input | 9 | Card clock rate in MHz |
| bus_mode | input | 3 | Bus timing mode code; 3 and 4 need tuning |
| probe_req | output | 1 | Request a trial at `probe_phase` |
| probe_phase | output | 4 | Phase under trial |
| probe_valid | input | 1 | Trial result strobe |
| probe_pass | input | 1 | Trial result, 1 = pass |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (one cycle) |
| sel_phase | output | 4 | Selected sampling phase |
| err_nopass | output | 1 | Three sweeps found no passing phase |
| err_select | output | 1 | Merged window length reached 16 |

## Verification
The assertions assume that the test engine raises `probe_valid` only while `probe_req` is high, that it holds the strobe for exactly one cycle, and that `start` is a pulse. The bench responder follows these rules. It waits a varying 0 to 2 cycles before answering and clears the strobe on the following cycle. The bench sends one start outside a run and one during a run to exercise the ignore rule. Expected phases come from a circular run search in the bench. That search orders windows by start phase, which is a different formulation from the linear scan with merging used in the design.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PROBE = 3'd1,
        S_GAP   = 3'd2,
        S_SCAN  = 3'd3,
        S_DONE  = 3'd4
    } ctrl_state_t;

endpackage

// File: rtl/pwt_run_scan.sv
module pwt_run_scan #(
    parameter int NUM_PHASES = 16,
    parameter int PH_W       = $clog2(NUM_PHASES),
    parameter int LEN_W      = PH_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [NUM_PHASES-1:0] mask,
    output logic                  scan_done,
    output logic [PH_W-1:0]       best_start,
    output logic [LEN_W-1:0]      best_len,
    output logic                  merge_err
);

    localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

    logic              active;
    logic [PH_W-1:0]   idx;
    logic              in_run;
    logic [PH_W-1:0]   run_start;
    logic [LEN_W-1:0]  run_len;
    logic [LEN_W-1:0]  zero_len;

    logic              bit_now;
    logic              wrap;
    logic              closing;
    logic [PH_W-1:0]   close_start;
    logic [LEN_W-1:0]  close_len;
    logic              is_zero_run;
    logic              is_tail;
    logic [LEN_W:0]    cand_sum;
    logic [LEN_W-1:0]  cand_len;
    logic              take;

    // Wrap merging applies only when both ends pass and some phase fails.
    assign wrap    = mask[0] & mask[NUM_PHASES-1] & ~(&mask);
    assign bit_now = mask[idx];

    always_comb begin
        closing     = 1'b0;
        close_start = run_start;
        close_len   = run_len;
        if (active) begin
            if (bit_now) begin
                close_start = in_run ? run_start : idx;
                close_len   = in_run ? run_len + 1'b1 : LEN_W'(1);
                closing     = (idx == LAST);
            end else begin
                closing = in_run;
            end
        end
        is_zero_run = wrap && (close_start == '0);
        is_tail     = wrap && bit_now && (idx == LAST);
        cand_sum    = {1'b0, close_len} + {1'b0, zero_len};
        cand_len    = is_tail ? cand_sum[LEN_W-1:0] : close_len;
        take        = closing && !is_zero_run && (cand_len > best_len);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active     <= 1'b0;
            idx        <= '0;
            in_run     <= 1'b0;
            run_start  <= '0;
            run_len    <= '0;
            zero_len   <= '0;
            best_start <= '0;
            best_len   <= '0;
            merge_err  <= 1'b0;
            scan_done  <= 1'b0;
        end else begin
            scan_done <= active && (idx == LAST);
            if (go) begin
                active     <= 1'b1;
                idx        <= '0;
                in_run     <= 1'b0;
                run_start  <= '0;
                run_len    <= '0;
                zero_len   <= '0;
                best_start <= '0;
                best_len   <= '0;
                merge_err  <= 1'b0;
            end else if (active) begin
                if (bit_now) begin
                    in_run    <= 1'b1;
                    run_start <= close_start;
                    run_len   <= close_len;
                end else begin
                    in_run <= 1'b0;
                end
                if (closing && is_zero_run) begin
                    zero_len <= close_len;
                end
                if (closing && is_tail && (cand_sum >= (LEN_W+1)'(NUM_PHASES))) begin
                    merge_err <= 1'b1;
                end
                if (take) begin
                    best_len   <= cand_len;
                    best_start <= close_start;
                end
                if (idx == LAST) begin
                    active <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R4: a finished scan never reports a window longer than the circle
    a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (best_len <= LEN_W'(NUM_PHASES)));

    // R4: a mask with any pass yields a non-empty window
    a_r4_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && (mask != '0)) |-> (best_len != '0));

endmodule

// File: rtl/pwt_pick.sv
module pwt_pick #(
    parameter int NUM_PHASES = 16,
    parameter int PH_W       = $clog2(NUM_PHASES),
    parameter int LEN_W      = PH_W + 1
) (
    input  logic [PH_W-1:0]  win_start,
    input  logic [LEN_W-1:0] win_len,
    output logic [PH_W-1:0]  pick_phase
);

    localparam int PW = LEN_W + 2;

    logic [PW-1:0]    triple;
    logic [LEN_W-1:0] quarter;
    logic [LEN_W-1:0] offset;

    always_comb begin
        triple     = ({2'b00, win_len} << 1) + {2'b00, win_len};
        quarter    = triple[PW-1:2];
        offset     = (quarter != '0) ? quarter - 1'b1 : '0;
        pick_phase = win_start + offset[PH_W-1:0];
    end

endmodule

// File: rtl/pwt_sweep_ctrl.sv
module pwt_sweep_ctrl
    import pwt_pkg::*;
#(
    parameter int NUM_PHASES  = 16,
    parameter int PH_W        = $clog2(NUM_PHASES),
    parameter int MAX_TRIES   = 3,
    parameter int FREQ_W      = 9,
    parameter int MODE_W      = 3,
    parameter int BYPASS_MHZ  = 100,
    parameter int FAST_MODE_A = 3,
    parameter int FAST_MODE_B = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FREQ_W-1:0]     freq_mhz,
    input  logic [MODE_W-1:0]     bus_mode,
    output logic                  probe_req,
    output logic [PH_W-1:0]       probe_phase,
    input  logic                  probe_valid,
    input  logic                  probe_pass,
    output logic [NUM_PHASES-1:0] pass_mask,
    output logic                  scan_go,
    input  logic                  scan_done,
    input  logic [PH_W-1:0]       pick_phase,
    input  logic                  pick_err,
    output logic                  busy,
    output logic                  done,
    output logic [PH_W-1:0]       sel_phase,
    output logic                  err_nopass,
    output logic                  err_select
);

    localparam int              TRY_W     = $clog2(MAX_TRIES + 1);
    localparam logic [PH_W-1:0] LAST      = PH_W'(NUM_PHASES - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES - 1);

    ctrl_state_t        state, state_n;
    logic [TRY_W-1:0]   tries;
    logic               bypass;
    logic               last_phase;
    logic               empty;

    assign bypass = (freq_mhz <= FREQ_W'(BYPASS_MHZ)) ||
                    !((bus_mode == MODE_W'(FAST_MODE_A)) ||
                      (bus_mode == MODE_W'(FAST_MODE_B)));
    assign last_phase = (probe_phase == LAST);
    assign empty      = (pass_mask == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:  if (start) state_n = bypass ? S_DONE : S_PROBE;
            S_PROBE: if (probe_valid) state_n = S_GAP;
            S_GAP: begin
                if (!last_phase)            state_n = S_PROBE;
                else if (!empty)            state_n = S_SCAN;
                else if (tries == TRY_LAST) state_n = S_DONE;
                else                        state_n = S_PROBE;
            end
            S_SCAN:  if (scan_done) state_n = S_DONE;
            S_DONE:  state_n = S_IDLE;
            default: state_n = S_IDLE;
        endcase
    end

    // Sweep data and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            probe_phase <= '0;
            pass_mask   <= '0;
            tries       <= '0;
            sel_phase   <= '0;
            err_nopass  <= 1'b0;
            err_select  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    probe_phase <= '0;
                    pass_mask   <= '0;
                    tries       <= '0;
                    sel_phase   <= '0;
                    err_nopass  <= 1'b0;
                    err_select  <= 1'b0;
                end
                S_PROBE: if (probe_valid) pass_mask[probe_phase] <= probe_pass;
                S_GAP: begin
                    if (!last_phase) begin
                        probe_phase <= probe_phase + 1'b1;
                    end else if (empty) begin
                        if (tries == TRY_LAST) begin
                            err_nopass <= 1'b1;
                        end else begin
                            tries       <= tries + 1'b1;
                            probe_phase <= '0;
                        end
                    end
                end
                S_SCAN: if (scan_done) begin
                    sel_phase  <= pick_err ? '0 : pick_phase;
                    err_select <= pick_err;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        probe_req = (state == S_PROBE);
        busy      = (state != S_IDLE);
        done      = (state == S_DONE);
        scan_go   = (state == S_GAP) && last_phase && !empty;
    end

    // R2: request holds with a stable phase until answered
    a_r2_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && !probe_valid) |=> (probe_req && $stable(probe_phase)));

    // R2: request drops for a cycle after each result
    a_r2_gap_after_result: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_req && probe_valid) |=> !probe_req);

    // R3: a bypassed start finishes on the next cycle without a request
    a_r3_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE) && start && bypass) |=> (done && !probe_req));

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the two error kinds never appear together
    a_r7_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(err_nopass && err_select));

endmodule

// File: rtl/phase_window_tuner.sv
module phase_window_tuner #(
    parameter int NUM_PHASES  = 16,
    parameter int MAX_TRIES   = 3,
    parameter int FREQ_W      = 9,
    parameter int MODE_W      = 3,
    parameter int BYPASS_MHZ  = 100,
    parameter int FAST_MODE_A = 3,
    parameter int FAST_MODE_B = 4,
    parameter int PH_W        = $clog2(NUM_PHASES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] freq_mhz,
    input  logic [MODE_W-1:0] bus_mode,
    output logic              probe_req,
    output logic [PH_W-1:0]   probe_phase,
    input  logic              probe_valid,
    input  logic              probe_pass,
    output logic              busy,
    output logic              done,
    output logic [PH_W-1:0]   sel_phase,
    output logic              err_nopass,
    output logic              err_select
);

    localparam int LEN_W = PH_W + 1;

    logic [NUM_PHASES-1:0] pass_mask;
    logic                  scan_go;
    logic                  scan_done;
    logic [PH_W-1:0]       best_start;
    logic [LEN_W-1:0]      best_len;
    logic                  merge_err;
    logic [PH_W-1:0]       pick_phase;

    pwt_sweep_ctrl #(
        .NUM_PHASES (NUM_PHASES),
        .PH_W       (PH_W),
        .MAX_TRIES  (MAX_TRIES),
        .FREQ_W     (FREQ_W),
        .MODE_W     (MODE_W),
        .BYPASS_MHZ (BYPASS_MHZ),
        .FAST_MODE_A(FAST_MODE_A),
        .FAST_MODE_B(FAST_MODE_B)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .freq_mhz   (freq_mhz),
        .bus_mode   (bus_mode),
        .probe_req  (probe_req),
        .probe_phase(probe_phase),
        .probe_valid(probe_valid),
        .probe_pass (probe_pass),
        .pass_mask  (pass_mask),
        .scan_go    (scan_go),
        .scan_done  (scan_done),
        .pick_phase (pick_phase),
        .pick_err   (merge_err),
        .busy       (busy),
        .done       (done),
        .sel_phase  (sel_phase),
        .err_nopass (err_nopass),
        .err_select (err_select)
    );

    pwt_run_scan #(
        .NUM_PHASES(NUM_PHASES),
        .PH_W      (PH_W),
        .LEN_W     (LEN_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (scan_go),
        .mask      (pass_mask),
        .scan_done (scan_done),
        .best_start(best_start),
        .best_len  (best_len),
        .merge_err (merge_err)
    );

    pwt_pick #(
        .NUM_PHASES(NUM_PHASES),
        .PH_W      (PH_W),
        .LEN_W     (LEN_W)
    ) u_pick (
        .win_start (best_start),
        .win_len   (best_len),
        .pick_phase(pick_phase)
    );

    // R2: each new request carries the phase after the previous one
    a_r2_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(probe_req) && (probe_phase != '0)) |->
            (probe_phase == PH_W'($past(probe_phase) + 1'b1)));

endmodule

// File: tb/phase_window_tuner_bench.sv
module phase_window_tuner_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [8:0] freq_mhz = 9'd150;
    logic [2:0] bus_mode = 3'd3;
    logic       probe_req;
    logic [3:0] probe_phase;
    logic       probe_valid = 1'b0;
    logic       probe_pass = 1'b0;
    logic       busy, done, err_nopass, err_select;
    logic [3:0] sel_phase;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [15:0] masks [3];
    int req_count = 0;
    int hold_cnt  = 0;
    int ord_bad   = 0;
    int last_valid_cyc = 0;

    phase_window_tuner u_phase_window_tuner (
        .clk(clk), .rst_n(rst_n), .start(start), .freq_mhz(freq_mhz),
        .bus_mode(bus_mode), .probe_req(probe_req), .probe_phase(probe_phase),
        .probe_valid(probe_valid), .probe_pass(probe_pass), .busy(busy),
        .done(done), .sel_phase(sel_phase), .err_nopass(err_nopass),
        .err_select(err_select)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Test engine model: answers after 0..2 cycles, strobe lasts one cycle
    initial forever begin
        @(negedge clk);
        if (probe_valid) begin
            probe_valid = 1'b0;
        end else if (rst_n && probe_req) begin
            if (int'(probe_phase) != (req_count % 16)) ord_bad++;
            if (hold_cnt < (req_count % 3)) begin
                hold_cnt++;
            end else begin
                probe_pass  = masks[(req_count / 16) > 2 ? 2 : (req_count / 16)][probe_phase];
                probe_valid = 1'b1;
                hold_cnt    = 0;
                req_count++;
                last_valid_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Circular model: runs start where a pass follows a fail; lowest start wins ties
    function automatic int model_phase(input logic [15:0] m);
        int best_l = 0;
        int best_s = 0;
        int k;
        if (m == 16'hFFFF) begin
            best_l = 16;
            best_s = 0;
        end else begin
            for (int s = 0; s < 16; s++) begin
                if (m[s] && !m[(s + 15) % 16]) begin
                    int l = 0;
                    while (m[(s + l) % 16]) l++;
                    if (l > best_l) begin
                        best_l = l;
                        best_s = s;
                    end
                end
            end
        end
        k = (best_l * 3) / 4;
        if (k > 0) k--;
        return (best_s + k) % 16;
    endfunction

    task automatic run_case(input logic [15:0] m0, input logic [15:0] m1,
                            input logic [15:0] m2, input int fr, input int md,
                            input bit poke);
        int  sweeps;
        int  exp_phase;
        bit  exp_nopass;
        bit  byp;
        bit  seen;
        int  lat;
        logic [3:0] held;
        masks[0] = m0; masks[1] = m1; masks[2] = m2;
        req_count = 0; hold_cnt = 0; ord_bad = 0;
        byp = (fr <= 100) || !((md == 3) || (md == 4));
        exp_nopass = 1'b0;
        exp_phase  = 0;
        sweeps     = 0;
        if (!byp) begin
            if (m0 != 0)      begin sweeps = 1; exp_phase = model_phase(m0); end
            else if (m1 != 0) begin sweeps = 2; exp_phase = model_phase(m1); end
            else if (m2 != 0) begin sweeps = 3; exp_phase = model_phase(m2); end
            else              begin sweeps = 3; exp_nopass = 1'b1; end
        end
        @(negedge clk);
        freq_mhz = 9'(fr);
        bus_mode = 3'(md);
        start    = 1'b1;
        seen     = 1'b0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            start = (poke && i == 6);
            if (done) begin
                seen = 1'b1;
                break;
            end
        end
        start = 1'b0;
        chk(seen, "R8 done seen", int'(seen), 1);
        if (!seen) return;
        lat = cyc - last_valid_cyc;
        chk(int'(sel_phase) == exp_phase, byp ? "R3 bypass phase" : "R4/R5/R6 phase",
            int'(sel_phase), exp_phase);
        chk(err_nopass == exp_nopass, "R7 err_nopass", int'(err_nopass), int'(exp_nopass));
        chk(err_select == 1'b0, "R4 err_select", int'(err_select), 0);
        chk(req_count == sweeps * 16, byp ? "R3 no requests" : "R2/R7 request count",
            req_count, sweeps * 16);
        chk(ord_bad == 0, "R2 phase order", ord_bad, 0);
        if (!byp && !exp_nopass) chk(lat <= 32, "R9 latency", lat, 32);
        held = sel_phase;
        @(negedge clk);
        chk(done == 1'b0, "R8 done pulse", int'(done), 0);
        @(negedge clk);
        chk(sel_phase == held && !busy, "R8 result held", int'(sel_phase), int'(held));
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cyc > 190000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        masks[0] = 16'h0; masks[1] = 16'h0; masks[2] = 16'h0;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !probe_req, "R1 reset control", int'({busy, done, probe_req}), 0);
        chk(!err_nopass && !err_select && sel_phase == 4'd0, "R1 reset results",
            int'({err_nopass, err_select, sel_phase}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 bypass conditions
        run_case(16'h00F0, 16'h0, 16'h0, 100, 3, 1'b0);
        run_case(16'h00F0, 16'h0, 16'h0, 200, 2, 1'b0);
        run_case(16'h00F0, 16'h0, 16'h0, 200, 0, 1'b0);
        // Tuned at 101 MHz in mode 4
        run_case(16'h00F0, 16'h0, 16'h0, 101, 4, 1'b0);

        // R4 wrap, all ones, single ends; R5 ties
        run_case(16'hFFFF, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'h8001, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'hF00F, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'h0F0F, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'hC3C3, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'h0001, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'h8000, 16'h0, 16'h0, 200, 3, 1'b0);
        run_case(16'h7FFE, 16'h0, 16'h0, 200, 3, 1'b0);

        // R7 retries
        run_case(16'h0, 16'h0100, 16'h0, 200, 3, 1'b0);
        run_case(16'h0, 16'h0, 16'h00F0, 200, 3, 1'b0);
        run_case(16'h0, 16'h0, 16'h0, 200, 4, 1'b0);

        // R8 start while busy is ignored
        run_case(16'h3C3C, 16'h0, 16'h0, 200, 3, 1'b1);

        // R6 sweep over many masks
        for (int k = 1; k < 1000; k++) begin
            logic [15:0] m;
            m = 16'(k * 40503) ^ 16'((k >> 3) * 7919);
            run_case(m, 16'h0, 16'hFFFF, 180, 3, 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule